// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a three-wire serial EEPROM link. A client hands it one instruction at a time over a small command port. The command port carries an operation code, a word-size selector, an address, write data and a burst length. The controller then runs the link pins. It raises chip select, produces a serial clock divided down from the system clock, and shifts out the start bit, the opcode, the address field and any data. On a read it collects the returned bits.

Instructions that program the array are not finished when their frame has been sent. The controller first lowers chip select so that the memory commits the instruction. It then selects the memory again and watches the data-out line until that line goes high, which means the memory is ready. If the line stays low for too long, the command ends with an error flag. A read may continue over several consecutive words under a single address phase.

All pin timing is set in system-clock cycles by parameters. `DIV` sets each serial clock phase, `GAP` sets the minimum deselect time, and `POLL_MAX` sets the busy-wait limit.

Top module: `ser_eeprom_host`

## Requirements
- R1: A frame starts with a 1 and then a two-bit opcode (read 10, write 01, erase 11, extended 00). The address field follows, 6 bits when `cmd_wide`=1 and 7 bits when `cmd_wide`=0. Everything is sent MSB first. `cmd_op` encodes the instructions as 0 read, 1 write, 2 erase, 3 program-enable, 4 program-disable, 5 erase-all, 6 write-all.
- R2: Extended instructions (`cmd_op` 3 to 6) send opcode 00. The two top bits of the address field select the instruction: 11 enable, 00 disable, 10 erase-all, 01 write-all. All other address bits are sent as 0.
- R3: Write and write-all frames end with the data word, MSB first. The word is 16 bits when `cmd_wide`=1 and `cmd_wdata[7:0]` when `cmd_wide`=0.
- R4: Each serial clock phase, high and low, lasts exactly `DIV` cycles. The first low phase follows the rise of `ee_cs`. `ee_sk` is low whenever `ee_cs` is low. `ee_di` changes only while `ee_sk` is low.
- R5: Each low period of `ee_cs` between two selections lasts at least `GAP` cycles.
- R6: On a read, the first bit returned after the address is a dummy and is dropped. In narrow mode the byte appears in `rd_data[7:0]`, with `rd_data[15:8]`=0.
- R7: A read with `cmd_len`=L returns L+1 consecutive words under one selection and one address phase. The memory advances and wraps its own pointer. `rd_vld` pulses once for each word.
- R8: For write, erase, erase-all and write-all, the controller deselects and then selects again without clocking. It samples `ee_do` until `ee_do` is 1, and only then deselects for `GAP` cycles and signals done. All other instructions use exactly one selection.
- R9: If `ee_do` stays low for `POLL_MAX` cycles while the controller polls, the command ends with `cmd_err`=1. `cmd_err` is high only together with `cmd_done`.
- R10: `cmd_start` is ignored unless the controller is idle.
- R11: `cmd_done` is a one-cycle pulse. It comes `GAP` cycles after the final fall of `ee_cs`. On that cycle `rd_data` holds the last word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Starts a command when idle |
| cmd_op | input | 3 | Instruction code |
| cmd_wide | input | 1 | 1: 16-bit words, 0: 8-bit words |
| cmd_addr | input | 7 | Word address (6 bits used when wide) |
| cmd_wdata | input | 16 | Write data |
| cmd_len | input | 4 | Extra words in a burst read |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Busy poll timed out (with done) |
| rd_vld | output | 1 | One read word is ready |
| rd_data | output | 16 | Read word |
| ee_cs | output | 1 | Chip select to the memory |
| ee_sk | output | 1 | Serial clock to the memory |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data / ready from the memory |

## Verification
Each read word is captured on the last cycle of its bit slot, so `rd_vld` rises on the next cycle. `cmd_done` follows the final fall of chip select after exactly `GAP` cycles. For program instructions, a poll phase of variable length comes before that final deselect. The bench therefore does not predict absolute cycle numbers. It waits on falling clock edges for each `rd_vld` and `cmd_done` pulse and compares the data and flags present in that same cycle. A behavioural memory model reports the bits it received at each deselect. A pin monitor measures every clock phase and every deselect gap on the falling edge, so all pin samples fall half a cycle away from the edges at which the controller changes its outputs.

// File: rtl/ser_eeprom_host.sv
module ser_eeprom_host #(
  parameter int DIV      = 4,
  parameter int GAP      = 8,
  parameter int POLL_MAX = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic [2:0]  cmd_op,
  input  logic        cmd_wide,
  input  logic [6:0]  cmd_addr,
  input  logic [15:0] cmd_wdata,
  input  logic [3:0]  cmd_len,
  output logic        cmd_done,
  output logic        cmd_err,
  output logic        rd_vld,
  output logic [15:0] rd_data,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do
);
  localparam int PHW = $clog2(2 * DIV) + 1;
  localparam int GW  = $clog2(GAP + 1) + 1;
  localparam int PW  = $clog2(POLL_MAX + 1) + 1;
  localparam logic [PHW-1:0] PH_HI  = PHW'(DIV);
  localparam logic [PHW-1:0] PH_END = PHW'(2 * DIV - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP, S_POLL} st_t;
  st_t st;

  logic [PHW-1:0] ph;
  logic [8:0]     bidx, nbits;
  logic [4:0]     hdr, dwq, wbit;
  logic [25:0]    frame;
  logic [15:0]    rx;
  logic           is_rd, is_prog, polled, err_q;
  logic [GW-1:0]  gcnt;
  logic [PW-1:0]  pcnt;

  logic [1:0]  opc, code;
  logic        ext, has_data, rd_op, prog_op;
  logic [4:0]  hdrn, dw;
  logic [5:0]  a16;
  logic [6:0]  a8;
  logic [8:0]  nb;
  logic [25:0] fr;

  always_comb begin
    case (cmd_op)
      3'd0:    opc = 2'b10;
      3'd1:    opc = 2'b01;
      3'd2:    opc = 2'b11;
      default: opc = 2'b00;
    endcase
    case (cmd_op)
      3'd3:    code = 2'b11;
      3'd5:    code = 2'b10;
      3'd6:    code = 2'b01;
      default: code = 2'b00;
    endcase
    ext      = cmd_op >= 3'd3;
    has_data = (cmd_op == 3'd1) || (cmd_op == 3'd6);
    rd_op    = cmd_op == 3'd0;
    prog_op  = (cmd_op == 3'd1) || (cmd_op == 3'd2) || (cmd_op == 3'd5) || (cmd_op == 3'd6);
    hdrn     = cmd_wide ? 5'd9 : 5'd10;
    dw       = cmd_wide ? 5'd16 : 5'd8;
    a16      = ext ? {code, 4'b0} : cmd_addr[5:0];
    a8       = ext ? {code, 5'b0} : cmd_addr;
    nb = 9'(hdrn) + (has_data ? 9'(dw) : 9'd0)
       + (rd_op ? 9'(dw) * (9'(cmd_len) + 9'd1) : 9'd0);
    fr = cmd_wide ? {1'b1, opc, a16, cmd_wdata, 1'b0}
                  : {1'b1, opc, a8, cmd_wdata[7:0], 8'b0};
  end

  assign ee_sk = (st == S_SHIFT) && (ph >= PH_HI);
  assign ee_di = (st == S_SHIFT) && frame[25];

  wire [15:0] rx_nxt = {rx[14:0], ee_do};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; bidx <= '0; nbits <= '0; hdr <= '0; dwq <= '0;
      wbit <= '0; frame <= '0; rx <= '0; is_rd <= 1'b0; is_prog <= 1'b0;
      polled <= 1'b0; err_q <= 1'b0; gcnt <= '0; pcnt <= '0;
      ee_cs <= 1'b0; cmd_done <= 1'b0; cmd_err <= 1'b0; rd_vld <= 1'b0; rd_data <= '0;
    end else begin
      cmd_done <= 1'b0;
      cmd_err  <= 1'b0;
      rd_vld   <= 1'b0;
      case (st)
        S_IDLE: if (cmd_start) begin
          frame <= fr; nbits <= nb; hdr <= hdrn; dwq <= dw;
          is_rd <= rd_op; is_prog <= prog_op;
          polled <= 1'b0; err_q <= 1'b0; wbit <= '0; bidx <= '0; ph <= '0;
          ee_cs <= 1'b1; st <= S_SHIFT;
        end
        S_SHIFT: begin
          if (ph == PH_END) begin
            ph    <= '0;
            frame <= {frame[24:0], 1'b0};
            bidx  <= bidx + 9'd1;
            if (is_rd && bidx >= 9'(hdr)) begin
              rx <= rx_nxt;
              if (wbit == dwq - 5'd1) begin
                wbit    <= '0;
                rd_vld  <= 1'b1;
                rd_data <= (dwq == 5'd16) ? rx_nxt : {8'h00, rx_nxt[7:0]};
              end else begin
                wbit <= wbit + 5'd1;
              end
            end
            if (bidx == nbits - 9'd1) begin
              st <= S_GAP; gcnt <= '0; ee_cs <= 1'b0;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        S_GAP: begin
          gcnt <= gcnt + 1'b1;
          if (gcnt == GW'(GAP - 1)) begin
            if (is_prog && !polled) begin
              st <= S_POLL; pcnt <= '0; ee_cs <= 1'b1;
            end else begin
              st <= S_IDLE; cmd_done <= 1'b1; cmd_err <= err_q;
            end
          end
        end
        S_POLL: begin
          pcnt <= pcnt + 1'b1;
          if (pcnt >= PW'(DIV) && ee_do) begin
            polled <= 1'b1; st <= S_GAP; gcnt <= '0; ee_cs <= 1'b0;
          end else if (pcnt == PW'(POLL_MAX)) begin
            err_q <= 1'b1; polled <= 1'b1; st <= S_GAP; gcnt <= '0; ee_cs <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [GW-1:0]  cs_lo;
  logic [PHW:0]   sk_hi, sk_lo;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_lo <= GW'(GAP); sk_hi <= '0; sk_lo <= (PHW+1)'(DIV);
    end else begin
      if (ee_cs) cs_lo <= '0;
      else if (cs_lo != GW'(GAP)) cs_lo <= cs_lo + 1'b1;
      sk_hi <= ee_sk ? sk_hi + 1'b1 : '0;
      if (ee_sk || !ee_cs) sk_lo <= '0;
      else if (sk_lo != (PHW+1)'(DIV)) sk_lo <= sk_lo + 1'b1;
    end
  end

  a_r4_sk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n) ee_sk |-> ee_cs);
  a_r4_di_stable:   assert property (@(posedge clk) disable iff (!rst_n) (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
  a_r4_sk_high:     assert property (@(posedge clk) disable iff (!rst_n) $fell(ee_sk) |-> sk_hi == (PHW+1)'(DIV));
  a_r4_sk_low:      assert property (@(posedge clk) disable iff (!rst_n) $rose(ee_sk) |-> sk_lo == (PHW+1)'(DIV));
  a_r5_cs_gap:      assert property (@(posedge clk) disable iff (!rst_n) $rose(ee_cs) |-> cs_lo == GW'(GAP));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) cmd_done |=> !cmd_done);
  a_r9_err_on_done: assert property (@(posedge clk) disable iff (!rst_n) cmd_err |-> cmd_done);
endmodule

// File: tb/test_ser_eeprom_host.sv
`timescale 1ns/1ps
module test_ser_eeprom_host;
  localparam int DIV = 3, GAP = 5, POLL_MAX = 300, BUSY_T = 80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 1'b0, cmd_wide = 1'b1;
  logic [2:0] cmd_op = '0;
  logic [6:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic [3:0] cmd_len = '0;
  logic cmd_done, cmd_err, rd_vld, ee_cs, ee_sk, ee_di, ee_do;
  logic [15:0] rd_data;

  always #2 clk = ~clk;

  ser_eeprom_host #(.DIV(DIV), .GAP(GAP), .POLL_MAX(POLL_MAX)) i_ser_eeprom_host (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op), .cmd_wide(cmd_wide),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len), .cmd_done(cmd_done),
    .cmd_err(cmd_err), .rd_vld(rd_vld), .rd_data(rd_data), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di), .ee_do(ee_do));

  int checks = 0, fails = 0;
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural memory model, evaluated on falling edges
  logic [15:0] mem [64];
  logic m_en, m_started, m_reading, m_pcs, m_psk, m_do, stuck = 1'b0;
  int m_k, m_busy, m_rbit, m_n, last_n;
  logic [1:0] m_op;
  logic [6:0] m_addr, m_ptr;
  logic [15:0] m_dat, m_word;
  logic [31:0] m_fr, last_fr;
  assign ee_do = m_do;

  function automatic logic [15:0] mrd(input logic w, input logic [6:0] a);
    if (w) return mem[a[5:0]];
    return a[0] ? {8'h00, mem[a[6:1]][7:0]} : {8'h00, mem[a[6:1]][15:8]};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
      m_en = 0; m_started = 0; m_reading = 0; m_pcs = 0; m_psk = 0; m_do = 1;
      m_k = 0; m_busy = 0; m_rbit = 0; m_n = 0; last_n = 0; m_fr = 0; last_fr = 0;
      m_op = 0; m_addr = 0; m_ptr = 0; m_dat = 0; m_word = 0;
    end else begin
      int aw, dw;
      aw = cmd_wide ? 6 : 7;
      dw = cmd_wide ? 16 : 8;
      if (m_busy > 0 && !stuck) m_busy = m_busy - 1;
      if (ee_cs && !m_pcs) begin
        m_n = 0; m_fr = 0; m_started = 0; m_reading = 0; m_k = 0;
      end
      if (!ee_cs && m_pcs) begin
        if (m_n > 0) begin last_fr = m_fr; last_n = m_n; end
        if (m_started && !m_reading && m_k >= 2 + aw) begin
          case (m_op)
            2'b01: if (m_en && m_k == 2 + aw + dw) begin
              if (cmd_wide) mem[m_addr[5:0]] = m_dat;
              else if (m_addr[0]) mem[m_addr[6:1]][7:0] = m_dat[7:0];
              else mem[m_addr[6:1]][15:8] = m_dat[7:0];
              m_busy = BUSY_T;
            end
            2'b11: if (m_en && m_k == 2 + aw) begin
              if (cmd_wide) mem[m_addr[5:0]] = 16'hFFFF;
              else if (m_addr[0]) mem[m_addr[6:1]][7:0] = 8'hFF;
              else mem[m_addr[6:1]][15:8] = 8'hFF;
              m_busy = BUSY_T;
            end
            2'b00: begin
              logic [1:0] c;
              c = cmd_wide ? m_addr[5:4] : m_addr[6:5];
              if (c == 2'b11) m_en = 1;
              else if (c == 2'b00) m_en = 0;
              else if (c == 2'b10 && m_en) begin
                for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
                m_busy = BUSY_T;
              end else if (c == 2'b01 && m_en && m_k == 2 + aw + dw) begin
                for (int i = 0; i < 64; i++) mem[i] = cmd_wide ? m_dat : {m_dat[7:0], m_dat[7:0]};
                m_busy = BUSY_T;
              end
            end
            default: ;
          endcase
        end
        m_started = 0; m_reading = 0;
      end
      if (ee_cs && ee_sk && !m_psk) begin
        m_fr = {m_fr[30:0], ee_di}; m_n++;
        if (m_reading) begin
          if (m_rbit == 0) begin
            m_ptr = cmd_wide ? {1'b0, m_ptr[5:0] + 6'd1} : m_ptr + 7'd1;
            m_word = mrd(cmd_wide, m_ptr); m_rbit = dw;
          end
          m_rbit--; m_do = m_word[m_rbit];
        end else if (!m_started) begin
          if (ee_di) begin m_started = 1; m_k = 0; m_op = 0; m_addr = 0; m_dat = 0; end
        end else begin
          m_k++;
          if (m_k <= 2) m_op = {m_op[0], ee_di};
          else if (m_k <= 2 + aw) m_addr = {m_addr[5:0], ee_di};
          else m_dat = {m_dat[14:0], ee_di};
          if (m_k == 2 + aw && m_op == 2'b10) begin
            m_reading = 1; m_ptr = m_addr; m_word = mrd(cmd_wide, m_addr); m_rbit = dw; m_do = 0;
          end
        end
      end
      if (ee_cs && !m_reading) m_do = (m_busy == 0);
      m_pcs = ee_cs; m_psk = ee_sk;
    end
  end

  // pin timing monitor
  int r4_viol = 0, r5_viol = 0, hi_run = 0, lo_run = 0, cs_low_run = 1000;
  logic p_sk = 0, p_cs = 0, p_di = 0;
  always @(negedge clk) if (rst_n) begin
    if (ee_sk && !ee_cs) r4_viol++;
    if (ee_sk && p_sk && ee_di != p_di) r4_viol++;
    if (!ee_sk && p_sk && hi_run != DIV) r4_viol++;
    if (ee_sk && !p_sk && lo_run != DIV) r4_viol++;
    if (ee_cs && !p_cs && cs_low_run < GAP) r5_viol++;
    hi_run = ee_sk ? hi_run + 1 : 0;
    lo_run = (ee_cs && !ee_sk) ? lo_run + 1 : 0;
    cs_low_run = ee_cs ? 0 : cs_low_run + 1;
    p_sk = ee_sk; p_cs = ee_cs; p_di = ee_di;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  logic [15:0] words [20];
  int nw, rises;
  logic [15:0] r_data;
  logic r_err;

  task automatic run_cmd(input logic [2:0] op, input logic w, input logic [6:0] a,
                         input logic [15:0] d, input logic [3:0] len);
    logic pc;
    int t;
    @(negedge clk);
    cmd_op = op; cmd_wide = w; cmd_addr = a; cmd_wdata = d; cmd_len = len; cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
    nw = 0; rises = 0; pc = 0; t = 0;
    if (ee_cs) begin rises = 1; pc = 1; end
    forever begin
      @(negedge clk);
      if (ee_cs && !pc) rises++;
      pc = ee_cs;
      if (rd_vld && nw < 20) begin words[nw] = rd_data; nw++; end
      if (cmd_done) begin r_data = rd_data; r_err = cmd_err; break; end
      t++;
      if (t > 20000) begin
        fails++; checks++;
        $display("FAIL R11 no done actual=timeout expected=done");
        break;
      end
    end
  endtask

  function automatic logic [31:0] exp_bits(input logic [2:0] op, input logic w,
                                           input logic [6:0] a, input logic [15:0] d);
    logic [63:0] v;
    int aw, dw;
    logic [1:0] opc, code;
    aw = w ? 6 : 7; dw = w ? 16 : 8;
    opc = (op == 0) ? 2'b10 : (op == 1) ? 2'b01 : (op == 2) ? 2'b11 : 2'b00;
    code = (op == 3) ? 2'b11 : (op == 5) ? 2'b10 : (op == 6) ? 2'b01 : 2'b00;
    v = 64'd1;
    v = (v << 2) | 64'(opc);
    if (op >= 3) v = (v << aw) | (64'(code) << (aw - 2));
    else v = (v << aw) | (64'(a) & ((64'd1 << aw) - 1));
    if (op == 1 || op == 6) v = (v << dw) | (64'(d) & ((64'd1 << dw) - 1));
    if (op == 0) v = v << dw;
    return v[31:0];
  endfunction

  function automatic int exp_len(input logic [2:0] op, input logic w);
    int n;
    n = w ? 9 : 10;
    if (op == 1 || op == 6 || op == 0) n += w ? 16 : 8;
    return n;
  endfunction

  // op, wide, addr, wdata, expected read, check read
  localparam int NV = 19;
  localparam logic [43:0] VEC [NV] = '{
    {3'd0, 1'b1, 7'd5,   16'h0000, 16'hFFFF, 1'b1},
    {3'd1, 1'b1, 7'd5,   16'h1234, 16'h0000, 1'b0},
    {3'd0, 1'b1, 7'd5,   16'h0000, 16'hFFFF, 1'b1},
    {3'd3, 1'b1, 7'd0,   16'h0000, 16'h0000, 1'b0},
    {3'd1, 1'b1, 7'd5,   16'hA5C3, 16'h0000, 1'b0},
    {3'd0, 1'b1, 7'd5,   16'h0000, 16'hA5C3, 1'b1},
    {3'd0, 1'b0, 7'd10,  16'h0000, 16'h00A5, 1'b1},
    {3'd0, 1'b0, 7'd11,  16'h0000, 16'h00C3, 1'b1},
    {3'd1, 1'b0, 7'd11,  16'h007E, 16'h0000, 1'b0},
    {3'd0, 1'b1, 7'd5,   16'h0000, 16'hA57E, 1'b1},
    {3'd2, 1'b1, 7'd5,   16'h0000, 16'h0000, 1'b0},
    {3'd0, 1'b1, 7'd5,   16'h0000, 16'hFFFF, 1'b1},
    {3'd6, 1'b1, 7'd0,   16'h0F0F, 16'h0000, 1'b0},
    {3'd0, 1'b1, 7'd63,  16'h0000, 16'h0F0F, 1'b1},
    {3'd5, 1'b0, 7'd0,   16'h0000, 16'h0000, 1'b0},
    {3'd0, 1'b0, 7'd127, 16'h0000, 16'h00FF, 1'b1},
    {3'd4, 1'b1, 7'd0,   16'h0000, 16'h0000, 1'b0},
    {3'd1, 1'b1, 7'd7,   16'h0000, 16'h0000, 1'b0},
    {3'd0, 1'b1, 7'd7,   16'h0000, 16'hFFFF, 1'b1}
  };

  initial begin
    repeat (4) @(negedge clk);
    check("R11 reset done", {31'd0, cmd_done}, 32'd0);
    check("R4 reset cs/sk", {30'd0, ee_cs, ee_sk}, 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic w;
      logic [6:0] a;
      logic [15:0] d, e;
      logic chk;
      int n;
      {op, w, a, d, e, chk} = VEC[i];
      run_cmd(op, w, a, d, 4'd0);
      n = exp_len(op, w);
      check("R1 R2 R3 frame length", 32'(last_n), 32'(n));
      check("R1 R2 R3 frame bits", last_fr & ((32'd1 << n) - 1), exp_bits(op, w, a, d));
      check("R9 no error", {31'd0, r_err}, 32'd0);
      check("R8 selections", 32'(rises),
            (op == 1 || op == 2 || op == 5 || op == 6) ? 32'd2 : 32'd1);
      if (chk) begin
        check("R6 read data", {16'd0, r_data}, {16'd0, e});
        check("R7 single word", 32'(nw), 32'd1);
      end
      repeat (3) @(negedge clk);
    end

    // burst read across the wrap point
    run_cmd(3'd3, 1'b1, 7'd0, 16'h0, 4'd0);
    run_cmd(3'd1, 1'b1, 7'd62, 16'hBEEF, 4'd0);
    check("R8 model idle at done", 32'(m_busy), 32'd0);
    run_cmd(3'd1, 1'b1, 7'd63, 16'hCAFE, 4'd0);
    run_cmd(3'd0, 1'b1, 7'd62, 16'h0, 4'd2);
    check("R7 burst word count", 32'(nw), 32'd3);
    check("R7 burst word0", {16'd0, words[0]}, 32'h0000BEEF);
    check("R7 burst word1", {16'd0, words[1]}, 32'h0000CAFE);
    check("R7 burst word2 wrap", {16'd0, words[2]}, 32'h0000FFFF);
    check("R11 last word at done", {16'd0, r_data}, 32'h0000FFFF);
    check("R7 one selection", 32'(rises), 32'd1);
    @(negedge clk);
    check("R11 done one cycle", {31'd0, cmd_done}, 32'd0);

    // start while busy is ignored
    @(negedge clk);
    cmd_op = 3'd0; cmd_wide = 1; cmd_addr = 7'd62; cmd_len = 0; cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
    repeat (20) @(negedge clk);
    cmd_op = 3'd1; cmd_addr = 7'd62; cmd_wdata = 16'h0000; cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
    begin
      int dn = 0;
      for (int t = 0; t < 1200; t++) begin
        @(negedge clk);
        if (cmd_done) dn++;
      end
      check("R10 one done only", 32'(dn), 32'd1);
    end
    run_cmd(3'd0, 1'b1, 7'd62, 16'h0, 4'd0);
    check("R10 ignored write left data", {16'd0, r_data}, 32'h0000BEEF);

    // busy poll timeout
    stuck = 1;
    run_cmd(3'd1, 1'b1, 7'd10, 16'h5555, 4'd0);
    check("R9 timeout error", {31'd0, r_err}, 32'd1);
    stuck = 0;
    repeat (BUSY_T + 20) @(negedge clk);
    run_cmd(3'd0, 1'b1, 7'd10, 16'h0, 4'd0);
    check("R9 error cleared", {31'd0, r_err}, 32'd0);

    check("R4 clock/data timing violations", 32'(r4_viol), 32'd0);
    check("R5 deselect gap violations", 32'(r5_viol), 32'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule